// File: doc/BRIEF.md
# LFSR Noise Voice

This block produces the pseudo-random voice of a sound generator. A 15-bit linear feedback shift register is stepped each time a programmable timer expires. Bit 0 of the register gates a 4-bit amplitude, which is either a fixed volume or the level of a decaying envelope. A length counter silences the voice after a programmed number of half-frame ticks.

The host writes four byte-wide control registers through a simple write strobe. A frame sequencer outside the block supplies three tick strobes: a timer tick at half the system rate, a quarter-frame tick for the envelope and a half-frame tick for the length counter. The block has no mixer and no frame sequencer. It outputs only the amplitude and a flag that is high while the length counter is non-zero.

Register layout, selected by `wr_addr_i`:
- Register 0: bits 3:0 are the volume or envelope rate, bit 4 selects constant volume, and bit 5 is the loop/halt bit.
- Register 1: has no effect.
- Register 2: bits 3:0 are the period index and bit 7 is the mode.
- Register 3: bits 7:3 are the length index.

Top module: `noise_voice`

## Requirements
- R1: After reset the amplitude is 0, the length flag is 0, the shift register holds 1 and the timer counter holds 0.
- R2: On each timer tick the timer counter decrements. On a tick that finds it at 0, it reloads from the period table and the shift register steps once. The table, indexed by register 2 bits 3:0, holds 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068. A new period index takes effect only at the next reload.
- R3: On a step, the feedback is bit 0 XOR bit 1 when register 2 bit 7 is 0, and bit 0 XOR bit 6 when it is 1. The register shifts right and the feedback enters bit 14.
- R4: The amplitude is 0 when the length counter is 0 or shift-register bit 0 is 1. Otherwise it is register 0 bits 3:0 when register 0 bit 4 is 1, and the envelope level when that bit is 0.
- R5: A write to register 3 while enabled loads the length counter from a 32-entry table indexed by bits 7:3. An odd index i gives i-1, except that index 1 gives 254. An even index 2k with k<8 gives 10,20,40,80,160,60,14,26 for k=0..7, and with k>=8 gives 12,24,48,96,192,72,16,32. A write while disabled leaves the counter unchanged. The length flag is 1 exactly when the counter is non-zero.
- R6: Each half-frame tick decrements a non-zero length counter, unless register 0 bit 5 is 1.
- R7: While the enable input is low, the length counter is forced to 0.
- R8: A write to register 3 arms an envelope restart. The next quarter-frame tick sets the level to 15 and the divider to register 0 bits 3:0. Each later tick decrements a non-zero divider. A tick that finds the divider at 0 reloads it and lowers a non-zero level by one. A level of 0 wraps to 15 when register 0 bit 5 is 1 and otherwise stays at 0.
- R9: Writes to register 1 change nothing, and without ticks the voice state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select 0..3 |
| wr_data_i | input | 8 | Write data |
| chan_en_i | input | 1 | Voice enable; low clears the length counter |
| tmr_tick_i | input | 1 | Half-rate timer tick |
| qtr_tick_i | input | 1 | Quarter-frame tick (envelope) |
| half_tick_i | input | 1 | Half-frame tick (length) |
| amp_o | output | 4 | Voice amplitude |
| len_active_o | output | 1 | Length counter non-zero |

## Verification
The assertions assume that each tick strobe is a single-cycle pulse. They also assume that the enable input changes only between clock edges, that register writes arrive one per cycle, and that no register-3 write shares a cycle with a quarter-frame tick. The stimulus keeps to these limits: every strobe is applied for exactly one cycle from a task, and writes and ticks are issued in separate cycles. A bench-side model of the timer, shift register, envelope and length counter then predicts the amplitude every cycle across both modes, several periods, all 32 length indices and both envelope loop settings.

// File: rtl/noise_pkg.sv
package noise_pkg;

   localparam int unsigned TBL_PERIOD_W = 12;
   localparam int unsigned TBL_LEN_W    = 8;

   typedef struct packed {
      logic       loop_halt;
      logic       const_vol;
      logic [3:0] vol;
   } vol_ctrl_t;

   typedef struct packed {
      logic       short_mode;
      logic [3:0] pidx;
   } rate_ctrl_t;

   function automatic logic [TBL_PERIOD_W-1:0] period_of(input logic [3:0] idx);
      logic [TBL_PERIOD_W-1:0] p;
      case (idx)
         4'd0:  p = 12'd4;
         4'd1:  p = 12'd8;
         4'd2:  p = 12'd16;
         4'd3:  p = 12'd32;
         4'd4:  p = 12'd64;
         4'd5:  p = 12'd96;
         4'd6:  p = 12'd128;
         4'd7:  p = 12'd160;
         4'd8:  p = 12'd202;
         4'd9:  p = 12'd254;
         4'd10: p = 12'd380;
         4'd11: p = 12'd508;
         4'd12: p = 12'd762;
         4'd13: p = 12'd1016;
         4'd14: p = 12'd2034;
         default: p = 12'd4068;
      endcase
      return p;
   endfunction

   function automatic logic [TBL_LEN_W-1:0] length_of(input logic [4:0] idx);
      logic [TBL_LEN_W-1:0] v;
      logic [2:0] m;
      m = idx[3:1];
      if (idx[0]) begin
         v = (idx == 5'd1) ? 8'd254 : {3'd0, idx} - 8'd1;
      end else begin
         case (m)
            3'd5:    v = idx[4] ? 8'd72 : 8'd60;
            3'd6:    v = idx[4] ? 8'd16 : 8'd14;
            3'd7:    v = idx[4] ? 8'd32 : 8'd26;
            default: v = (idx[4] ? 8'd12 : 8'd10) << m;
         endcase
      end
      return v;
   endfunction

endpackage

// File: rtl/noise_timer_lfsr.sv
module noise_timer_lfsr #(
   parameter int unsigned LFSR_W    = 15,
   parameter int unsigned TMR_W     = 12,
   parameter int unsigned TAP_LONG  = 1,
   parameter int unsigned TAP_SHORT = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             short_mode_i,
   input  logic [TMR_W-1:0] period_i,
   output logic             bit0_o
);

   if (TAP_LONG == 0 || TAP_LONG >= LFSR_W) begin : g_bad_long
      $error("noise_timer_lfsr: TAP_LONG out of range");
   end
   if (TAP_SHORT == 0 || TAP_SHORT >= LFSR_W) begin : g_bad_short
      $error("noise_timer_lfsr: TAP_SHORT out of range");
   end

   logic [TMR_W-1:0]  cnt_q;
   logic [LFSR_W-1:0] sr_q;
   logic              fb;
   logic              expire;

   assign expire = tick_i && (cnt_q == '0);
   assign fb     = sr_q[0] ^ (short_mode_i ? sr_q[TAP_SHORT] : sr_q[TAP_LONG]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         sr_q  <= LFSR_W'(1);
      end else if (tick_i) begin
         if (expire) begin
            cnt_q <= period_i;
            sr_q  <= {fb, sr_q[LFSR_W-1:1]};
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign bit0_o = sr_q[0];

   // R3: the shift register can never reach the all-zero lock-up state
   a_r3_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sr_q != '0);
   // R9: without a timer tick the shift register holds
   a_r9_lfsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(sr_q));
   // R2: a tick with a non-zero count only counts down
   a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && $stable(sr_q));

endmodule

// File: rtl/noise_envelope.sv
module noise_envelope #(
   parameter int unsigned VOL_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             qtick_i,
   input  logic             loop_i,
   input  logic [VOL_W-1:0] rate_i,
   output logic [VOL_W-1:0] level_o
);

   localparam logic [VOL_W-1:0] LVL_MAX = '1;

   logic             arm_q;
   logic [VOL_W-1:0] div_q;
   logic [VOL_W-1:0] lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_q <= 1'b0;
         div_q <= '0;
         lvl_q <= '0;
      end else begin
         if (qtick_i) begin
            if (arm_q) begin
               div_q <= rate_i;
               lvl_q <= LVL_MAX;
            end else if (div_q != '0) begin
               div_q <= div_q - 1'b1;
            end else begin
               div_q <= rate_i;
               if (lvl_q != '0)  lvl_q <= lvl_q - 1'b1;
               else if (loop_i)  lvl_q <= LVL_MAX;
            end
         end
         if (restart_i)    arm_q <= 1'b1;
         else if (qtick_i) arm_q <= 1'b0;
      end
   end

   assign level_o = lvl_q;

   // R8: the level moves only on a quarter-frame tick
   a_r8_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !qtick_i |=> $stable(lvl_q));
   // R8: an armed restart lands the level at full scale
   a_r8_restart_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_q && qtick_i) |=> lvl_q == LVL_MAX);

endmodule

// File: rtl/noise_length.sv
module noise_length #(
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             load_i,
   input  logic [LEN_W-1:0] load_val_i,
   input  logic             htick_i,
   input  logic             halt_i,
   output logic             active_o
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cnt_q <= '0;
      else if (!en_i)                       cnt_q <= '0;
      else if (load_i)                      cnt_q <= load_val_i;
      else if (htick_i && !halt_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   // R7: a low enable empties the counter on the next edge
   a_r7_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !active_o);
   // R6: halt freezes the counter when nothing is loaded
   a_r6_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && halt_i && !load_i) |=> $stable(cnt_q));
   // R6: the counter never wraps below zero
   a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0 && !load_i) |=> cnt_q == '0);

endmodule

// File: rtl/noise_voice.sv
module noise_voice #(
   parameter int unsigned LFSR_W    = 15,
   parameter int unsigned TMR_W     = 12,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned TAP_LONG  = 1,
   parameter int unsigned TAP_SHORT = 6,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_en_i,
   input  logic [1:0] wr_addr_i,
   input  logic [7:0] wr_data_i,
   input  logic       chan_en_i,
   input  logic       tmr_tick_i,
   input  logic       qtr_tick_i,
   input  logic       half_tick_i,
   output logic [3:0] amp_o,
   output logic       len_active_o
);
   import noise_pkg::*;

   localparam int unsigned VOL_W = 4;

   if (TMR_W < TBL_PERIOD_W) begin : g_bad_tmr
      $error("noise_voice: TMR_W narrower than the period table");
   end
   if (LEN_W < TBL_LEN_W) begin : g_bad_len
      $error("noise_voice: LEN_W narrower than the length table");
   end

   vol_ctrl_t  vctl_q;
   rate_ctrl_t rctl_q;
   logic       wr_vol, wr_rate, wr_len;

   assign wr_vol  = wr_en_i && (wr_addr_i == 2'd0);
   assign wr_rate = wr_en_i && (wr_addr_i == 2'd2);
   assign wr_len  = wr_en_i && (wr_addr_i == 2'd3);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vctl_q <= '0;
         rctl_q <= '0;
      end else begin
         if (wr_vol)  vctl_q <= '{loop_halt: wr_data_i[5], const_vol: wr_data_i[4], vol: wr_data_i[3:0]};
         if (wr_rate) rctl_q <= '{short_mode: wr_data_i[7], pidx: wr_data_i[3:0]};
      end
   end

   logic             sr_bit0;
   logic [VOL_W-1:0] env_lvl;
   logic             len_act;
   logic [VOL_W-1:0] amp_d;

   noise_timer_lfsr #(
      .LFSR_W(LFSR_W), .TMR_W(TMR_W), .TAP_LONG(TAP_LONG), .TAP_SHORT(TAP_SHORT)
   ) u_tmr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tmr_tick_i),
      .short_mode_i (rctl_q.short_mode),
      .period_i     (TMR_W'(period_of(rctl_q.pidx))),
      .bit0_o       (sr_bit0)
   );

   noise_envelope #(.VOL_W(VOL_W)) u_env (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (wr_len),
      .qtick_i   (qtr_tick_i),
      .loop_i    (vctl_q.loop_halt),
      .rate_i    (vctl_q.vol),
      .level_o   (env_lvl)
   );

   noise_length #(.LEN_W(LEN_W)) u_len (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (chan_en_i),
      .load_i     (wr_len),
      .load_val_i (LEN_W'(length_of(wr_data_i[7:3]))),
      .htick_i    (half_tick_i),
      .halt_i     (vctl_q.loop_halt),
      .active_o   (len_act)
   );

   always_comb begin
      if (!len_act || sr_bit0) amp_d = '0;
      else if (vctl_q.const_vol) amp_d = vctl_q.vol;
      else                       amp_d = env_lvl;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            amp_o        <= '0;
            len_active_o <= 1'b0;
         end else begin
            amp_o        <= amp_d;
            len_active_o <= len_act;
         end
      end
   end else begin : g_out_comb
      assign amp_o        = amp_d;
      assign len_active_o = len_act;

      // R4: a sounding output always implies a live length counter
      a_r4_gate_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (amp_o != '0) |-> len_active_o);
      // R5: a load while disabled never lights the length flag
      a_r5_no_load_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!chan_en_i) |=> !len_active_o);
   end

endmodule

// File: tb/sim_noise_voice.sv
`timescale 1ns/1ps
module sim_noise_voice;

   localparam real CLK_NS = 20.0;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, chan_en, tmr_tick, qtr_tick, half_tick;
   logic [1:0] wr_addr;
   logic [7:0] wr_data;
   logic [3:0] amp;
   logic       len_active;

   always #(CLK_NS/2.0) clk = ~clk;

   noise_voice u0 (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .chan_en_i(chan_en), .tmr_tick_i(tmr_tick),
      .qtr_tick_i(qtr_tick), .half_tick_i(half_tick),
      .amp_o(amp), .len_active_o(len_active)
   );

   int n_chk = 0, n_bad = 0;
   string cur_req = "R1";
   bit finished = 0;

   // bench model
   logic [14:0] m_sr;
   int m_tcnt, m_len, m_div, m_lvl;
   bit m_arm;
   logic [7:0] m_r0, m_r2;

   function automatic int per_tab(input int i);
      int t[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};
      return t[i];
   endfunction

   function automatic int len_tab(input int i);
      int k, g, m;
      if (i % 2 == 1) return (i == 1) ? 254 : i - 1;
      k = i / 2; g = k / 8; m = k % 8;
      if (m < 5) return (g ? 12 : 10) << m;
      if (m == 5) return g ? 72 : 60;
      if (m == 6) return g ? 16 : 14;
      return g ? 32 : 26;
   endfunction

   function automatic int exp_amp();
      if (m_len == 0 || m_sr[0]) return 0;
      if (m_r0[4]) return int'(m_r0[3:0]);
      return m_lvl;
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit t, input bit q, input bit h, input bit w,
                      input logic [1:0] a, input logic [7:0] d);
      logic fb;
      tmr_tick = t; qtr_tick = q; half_tick = h;
      wr_en = w; wr_addr = a; wr_data = d;
      @(posedge clk);
      // timer and shift register (R2, R3)
      if (t) begin
         if (m_tcnt == 0) begin
            m_tcnt = per_tab(int'(m_r2[3:0]));
            fb = m_sr[0] ^ (m_r2[7] ? m_sr[6] : m_sr[1]);
            m_sr = {fb, m_sr[14:1]};
         end else m_tcnt--;
      end
      // envelope (R8)
      if (q) begin
         if (m_arm) begin
            m_div = int'(m_r0[3:0]); m_lvl = 15;
         end else if (m_div > 0) m_div--;
         else begin
            m_div = int'(m_r0[3:0]);
            if (m_lvl > 0) m_lvl--;
            else if (m_r0[5]) m_lvl = 15;
         end
      end
      if (w && a == 2'd3) m_arm = 1;
      else if (q) m_arm = 0;
      // length (R5, R6, R7)
      if (!chan_en) m_len = 0;
      else if (w && a == 2'd3) m_len = len_tab(int'(d[7:3]));
      else if (h && !m_r0[5] && m_len > 0) m_len--;
      if (w && a == 2'd0) m_r0 = d;
      if (w && a == 2'd2) m_r2 = d;
      @(negedge clk);
      tmr_tick = 0; qtr_tick = 0; half_tick = 0; wr_en = 0;
      check(cur_req, int'(amp), exp_amp(), "amp");
      check(cur_req, int'(len_active), (m_len != 0) ? 1 : 0, "len_active");
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cyc(0, 0, 0, 1, a, d);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 0; chan_en = 0; tmr_tick = 0; qtr_tick = 0; half_tick = 0;
      wr_en = 0; wr_addr = 0; wr_data = 0;
      m_sr = 15'd1; m_tcnt = 0; m_len = 0; m_div = 0; m_lvl = 0; m_arm = 0;
      m_r0 = 0; m_r2 = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state at the ports
      check("R1", int'(amp), 0, "amp after reset");
      check("R1", int'(len_active), 0, "len_active after reset");

      // R5: a length write while disabled is ignored
      cur_req = "R5";
      wr(2'd0, 8'h1F);
      wr(2'd3, 8'h08);
      cyc(0, 0, 1, 0, 0, 0);

      // R1: the first timer tick after reset steps the register (1 -> 0x4000 opens the gate)
      chan_en = 1;
      wr(2'd3, 8'h00);
      cur_req = "R1";
      cyc(1, 0, 0, 0, 0, 0);
      check("R1", int'(amp), 15, "amp after first step from seed 1");

      // R5/R6: every length index counts down to zero on half-frame ticks
      cur_req = "R6";
      for (int i = 0; i < 32; i++) begin
         wr(2'd3, 8'(i << 3));
         check("R5", int'(len_active), 1, "flag after load");
         for (int k = 0; k < 300 && m_len > 0; k++) cyc(0, 0, 1, 0, 0, 0);
         cyc(0, 0, 1, 0, 0, 0);
      end

      // R6: halt bit freezes the counter
      wr(2'd0, 8'h3F);
      wr(2'd3, 8'h00);
      for (int k = 0; k < 20; k++) cyc(0, 0, 1, 0, 0, 0);
      check("R6", int'(len_active), 1, "halted counter still live");

      // R7: dropping enable clears the counter, re-enabling does not restore it
      cur_req = "R7";
      chan_en = 0;
      cyc(0, 0, 0, 0, 0, 0);
      chan_en = 1;
      cyc(0, 0, 0, 0, 0, 0);
      check("R7", int'(len_active), 0, "counter after enable drop");

      // R2/R3/R4: both modes, several periods, dense and sparse ticks
      cur_req = "R3";
      for (int mode = 0; mode < 2; mode++) begin
         for (int p = 0; p < 4; p++) begin
            wr(2'd2, 8'((mode << 7) | p));
            wr(2'd0, 8'(8'h30 | (p + 5)));
            wr(2'd3, 8'h00);
            for (int k = 0; k < 300; k++) begin
               cur_req = (k % 3 == 0) ? "R2" : ((k % 3 == 1) ? "R3" : "R4");
               cyc(1, 0, 0, 0, 0, 0);
               if (p == 3) cyc(0, 0, 0, 0, 0, 0);
            end
         end
      end

      // R8: envelope with loop, then without
      cur_req = "R8";
      wr(2'd2, 8'h00);
      for (int k = 0; k < 40 && m_sr[0]; k++) cyc(1, 0, 0, 0, 0, 0);
      wr(2'd0, 8'h22);
      wr(2'd3, 8'h00);
      for (int k = 0; k < 80; k++) cyc(0, 1, 0, 0, 0, 0);
      wr(2'd0, 8'h01);
      wr(2'd3, 8'h00);
      for (int k = 0; k < 40; k++) cyc(0, 1, 0, 0, 0, 0);
      check("R8", int'(amp), 0, "decay holds at zero without loop");

      // R9: register 1 writes and idle cycles change nothing
      cur_req = "R9";
      wr(2'd0, 8'h1A);
      wr(2'd3, 8'h00);
      wr(2'd1, 8'hFF);
      for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, 0, 0);
      check("R9", int'(len_active), 1, "length after register 1 write");

      finish_run();
   end

endmodule